// File: doc/BRIEF.md
# DDR Refresh Interval Scheduler

This block keeps time for a DDR memory controller and tells the command arbiter when an auto-refresh is due. The device must receive 4096 refreshes in every 64 ms, which works out to one every 15.6 us on average. An interval timer, whose reload value comes from the clock period, adds one refresh to a debt counter each time it expires. The arbiter may let refreshes wait. While the debt is non-zero and no recovery window is open, the block raises a refresh request. Once eight refreshes are owed, it raises an urgent flag so that the arbiter stops postponing them.

The arbiter grants a request only after it has made sure that every bank is precharged. Each grant pays back one refresh and opens a recovery window of tRFC clocks, during which the busy output blocks new row commands. The block also handles self-refresh. On an entry request it drives the clock-enable low and clears the debt, because the device refreshes itself. While in self-refresh the interval timer stays at its full value. On an exit request it raises the clock-enable and holds busy for the long exit blackout. The interval count then starts again from its full value.

Top module: `ddr_refresh_sched`

## Requirements
- R1: While reset is high and in the cycle after it drops, ref_req, ref_urgent and busy are 0 and cke is 1.
- R2: With en high in normal mode, one refresh is added to the debt every REFI_CYC = REFI_PS / CLK_PERIOD_PS clocks. Counting from reset or from a self-refresh exit, the first addition is made on the REFI_CYC-th enabled rising edge.
- R3: While en is low, the interval timer holds its count and adds no debt.
- R4: ref_req is 1 exactly when the debt is non-zero, the block is not in self-refresh and busy is 0. ref_urgent is 1 exactly when the debt equals MAX_OWED. When the debt is at MAX_OWED, further expiries leave it at MAX_OWED.
- R5: A grant taken while ref_req is 1 lowers the debt by one. A grant while ref_req is 0 changes nothing.
- R6: After an accepted grant, busy is 1 for exactly TRFC_CYC clocks, starting with the next cycle, and ref_req is held at 0 for that time.
- R7: An entry request is accepted only in normal mode with busy at 0. On acceptance cke goes to 0 in the next cycle and the debt is cleared. An entry request while busy is 1 leaves cke at 1.
- R8: In self-refresh, cke stays 0, ref_req stays 0, and the interval timer adds no debt.
- R9: An exit request in self-refresh drives cke to 1 in the next cycle and holds busy at 1 for exactly TXSR_CYC clocks. The interval timer starts again from its full count.
- R10: An exit request outside self-refresh has no effect on cke or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Enables the interval timer |
| grant | input | 1 | Arbiter issued the auto-refresh (all banks idle) |
| sr_enter_req | input | 1 | Request to enter self-refresh |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | A refresh is owed and may be issued |
| ref_urgent | output | 1 | The debt has reached its limit |
| cke | output | 1 | Clock-enable to the device |
| busy | output | 1 | Recovery or exit blackout in progress; no row commands |

## Verification
The assertions assume that the arbiter treats grant as meaningful only while ref_req is high, and that it has already idled all banks before it asserts grant or a self-refresh entry request. The stimulus follows these rules. Grants are single-cycle pulses, and they are sent while ref_req is high, except for the one deliberate case that shows a stray grant is ignored. Entry and exit requests are also single-cycle pulses. The deliberately misplaced ones are sent during busy or in normal mode, to show that they are rejected.

// File: rtl/ddr_ref_pkg.sv
package ddr_ref_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SELF = 2'd1,
    ST_WAKE = 2'd2
  } ref_state_e;
endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int unsigned REFI_CYC = 3900
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic reload,
  output logic tick
);
  localparam int unsigned CNT_W = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(REFI_CYC - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      cnt <= FULL;
    end else if (run) begin
      if (cnt == '0) cnt <= FULL;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign tick = run && !reload && (cnt == '0);

  // R3
  timer_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !reload) |=> $stable(cnt));
endmodule

// File: rtl/ref_debt_counter.sv
module ref_debt_counter #(
  parameter int unsigned MAX_OWED = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic add,
  input  logic take,
  input  logic clear,
  output logic nonzero,
  output logic full
);
  localparam int unsigned OW_W = $clog2(MAX_OWED + 1);
  localparam logic [OW_W-1:0] LIMIT = OW_W'(MAX_OWED);

  logic [OW_W-1:0] owed;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      owed <= '0;
    end else if (add && !take) begin
      if (owed != LIMIT) owed <= owed + 1'b1;
    end else if (take && !add) begin
      if (owed != '0) owed <= owed - 1'b1;
    end
  end

  assign nonzero = (owed != '0);
  assign full    = (owed == LIMIT);

  // R4
  owed_le_max_chk: assert property (@(posedge clk) disable iff (rst)
    owed <= LIMIT);
  // R5
  take_dec_chk: assert property (@(posedge clk) disable iff (rst)
    (take && !add && !clear && owed != '0) |=> owed == $past(owed) - 1'b1);
endmodule

// File: rtl/ref_lockout_timer.sv
module ref_lockout_timer #(
  parameter int unsigned DURATION = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic active,
  output logic last
);
  localparam int unsigned LW = $clog2(DURATION + 1);
  localparam logic [LW-1:0] START = LW'(DURATION);

  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= START;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign active = (cnt != '0);
  assign last   = (cnt == LW'(1));

  // R6
  lock_start_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> active);
endmodule

// File: rtl/ddr_refresh_sched.sv
module ddr_refresh_sched
  import ddr_ref_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 4000,
  parameter int unsigned REFI_PS       = 15600000,
  parameter int unsigned TRFC_CYC      = 16,
  parameter int unsigned TXSR_CYC      = 200,
  parameter int unsigned MAX_OWED      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic grant,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  output logic ref_req,
  output logic ref_urgent,
  output logic cke,
  output logic busy
);
  localparam int unsigned REFI_CYC = REFI_PS / CLK_PERIOD_PS;

  ref_state_e state;
  logic       cke_q;
  logic       tick, owed_nz, owed_full;
  logic       rfc_active, rfc_last, xsr_active, xsr_last;
  logic       take, enter_go, exit_go;

  assign busy     = rfc_active || xsr_active;
  assign ref_req  = owed_nz && (state != ST_SELF) && !busy;
  assign take     = grant && ref_req;
  assign enter_go = (state == ST_RUN) && sr_enter_req && !busy;
  assign exit_go  = (state == ST_SELF) && sr_exit_req;

  ref_interval_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk(clk), .rst(rst),
    .run(en && (state != ST_SELF)),
    .reload(state == ST_SELF),
    .tick(tick)
  );

  ref_debt_counter #(.MAX_OWED(MAX_OWED)) u_debt (
    .clk(clk), .rst(rst),
    .add(tick), .take(take), .clear(enter_go),
    .nonzero(owed_nz), .full(owed_full)
  );

  ref_lockout_timer #(.DURATION(TRFC_CYC)) u_rfc (
    .clk(clk), .rst(rst), .load(take),
    .active(rfc_active), .last(rfc_last)
  );

  ref_lockout_timer #(.DURATION(TXSR_CYC)) u_xsr (
    .clk(clk), .rst(rst), .load(exit_go),
    .active(xsr_active), .last(xsr_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_RUN;
      cke_q <= 1'b1;
    end else begin
      case (state)
        ST_RUN:  if (enter_go) begin state <= ST_SELF; cke_q <= 1'b0; end
        ST_SELF: if (exit_go)  begin state <= ST_WAKE; cke_q <= 1'b1; end
        ST_WAKE: if (xsr_last) state <= ST_RUN;
        default: state <= ST_RUN;
      endcase
    end
  end

  assign cke        = cke_q;
  assign ref_urgent = owed_full;

  logic unused_ok;
  assign unused_ok = rfc_last;

  // R6
  grant_busy_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> (busy && !ref_req));
  // R8
  sr_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |-> !ref_req);
  // R7
  cke_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cke) |-> ($past(sr_enter_req) && !$past(busy)));
  // R9
  cke_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (busy && $past(sr_exit_req)));
endmodule

// File: tb/test_ddr_refresh_sched.sv
`timescale 1ns/1ps
module test_ddr_refresh_sched;
  localparam int unsigned REFI = 100;
  localparam int unsigned TRFC = 16;
  localparam int unsigned TXSR = 30;

  logic clk = 1'b0;
  logic rst, en, grant, sr_enter_req, sr_exit_req;
  logic ref_req, ref_urgent, cke, busy;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  always #5 clk = ~clk;

  ddr_refresh_sched #(
    .CLK_PERIOD_PS(4000), .REFI_PS(REFI * 4000),
    .TRFC_CYC(TRFC), .TXSR_CYC(TXSR), .MAX_OWED(8)
  ) i_ddr_refresh_sched (
    .clk(clk), .rst(rst), .en(en), .grant(grant),
    .sr_enter_req(sr_enter_req), .sr_exit_req(sr_exit_req),
    .ref_req(ref_req), .ref_urgent(ref_urgent), .cke(cke), .busy(busy)
  );

  // cycles, expected ref_req, expected ref_urgent
  localparam logic [17:0] VEC [5] = '{
    {16'd99,  1'b0, 1'b0},
    {16'd1,   1'b1, 1'b0},
    {16'd600, 1'b1, 1'b0},
    {16'd100, 1'b1, 1'b1},
    {16'd100, 1'b1, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 1'b0; grant = 1'b0;
    sr_enter_req = 1'b0; sr_exit_req = 1'b0;
    step(3);
    rst = 1'b0; en = 1'b1;
  endtask

  task automatic pulse_grant();
    grant = 1'b1; step(1); grant = 1'b0;
  endtask

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 ref_req", ref_req, 1'b0);
    chk("R1 ref_urgent", ref_urgent, 1'b0);
    chk("R1 cke", cke, 1'b1);
    chk("R1 busy", busy, 1'b0);

    // R2 R4 interval and debt accumulation with saturation
    for (int i = 0; i < 5; i++) begin
      step(int'(VEC[i][17:2]));
      chk("R2/R4 ref_req", ref_req, VEC[i][1]);
      chk("R4 ref_urgent", ref_urgent, VEC[i][0]);
    end

    // R5 R6 grant pays one back and opens tRFC window
    pulse_grant();
    chk("R5 urgent clears", ref_urgent, 1'b0);
    chk("R6 busy starts", busy, 1'b1);
    chk("R6 req masked", ref_req, 1'b0);
    step(TRFC - 1);
    chk("R6 busy last cycle", busy, 1'b1);
    step(1);
    chk("R6 busy ends", busy, 1'b0);
    chk("R6 req returns", ref_req, 1'b1);

    for (int k = 0; k < 20 && ref_req; k++) begin
      pulse_grant();
      step(TRFC);
    end
    chk("R5 debt drained", ref_req, 1'b0);
    chk("R4 urgent drained", ref_urgent, 1'b0);

    // R5 stray grant ignored
    pulse_grant();
    chk("R5 stray grant busy", busy, 1'b0);

    // R3 en low holds timer
    en = 1'b0;
    step(500);
    chk("R3 no debt while disabled", ref_req, 1'b0);

    // Self-refresh sequence
    do_reset();
    step(150);
    chk("R2 req before sr", ref_req, 1'b1);
    pulse_grant();
    sr_enter_req = 1'b1; step(1); sr_enter_req = 1'b0;
    chk("R7 entry refused while busy", cke, 1'b1);
    step(16);
    step(40);
    chk("R2 second interval", ref_req, 1'b1);
    sr_enter_req = 1'b1; step(1); sr_enter_req = 1'b0;
    chk("R7 cke low", cke, 1'b0);
    chk("R7 req low", ref_req, 1'b0);
    step(300);
    chk("R8 cke held low", cke, 1'b0);
    chk("R8 no req", ref_req, 1'b0);
    chk("R8 not busy", busy, 1'b0);
    sr_exit_req = 1'b1; step(1); sr_exit_req = 1'b0;
    chk("R9 cke high", cke, 1'b1);
    chk("R9 busy starts", busy, 1'b1);
    step(TXSR - 1);
    chk("R9 busy last cycle", busy, 1'b1);
    step(1);
    chk("R9 busy ends", busy, 1'b0);
    chk("R7 debt cleared", ref_req, 1'b0);
    step(REFI - TXSR - 1);
    chk("R9 timer restarted full", ref_req, 1'b0);
    step(1);
    chk("R9 first tick after exit", ref_req, 1'b1);

    // R10 exit outside self-refresh
    sr_exit_req = 1'b1; step(1); sr_exit_req = 1'b0;
    chk("R10 cke", cke, 1'b1);
    chk("R10 busy", busy, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule